// File: doc/BRIEF.md
# I2C Bus Interval Timer

This block times every interval that an I2C master spends in one bus phase. A bit-level sequencer asks for a phase: SCL low, SCL high, START setup, START hold, STOP setup, data setup, data hold or bus release after a STOP. The timer counts that phase out and then returns a one-cycle strobe, tagged with the phase, which tells the sequencer to move SCL or SDA. The sequencer keeps all decisions about pin levels. The timer only decides when.

All intervals count ticks of a shared prescaler. Each interval length is a programmed 8-bit field, and a field holding N lasts N+1 ticks. The SCL-high phase first waits a fixed overhead of 8 plus twice the input-filter setting, counted in system clocks. A full low-plus-high SCL period therefore takes (DIV+1)·(LO+HI+2) + 8 + 2·FLT system clocks. A hold-off input stands for a slave that stretches the clock. While it is high, the SCL-high count does not begin.

The timing fields are captured when the bus is idle and frozen between a START and the end of the following release phase. Rewriting a timing word during a transfer therefore only affects the next transfer.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `busy` and `bus_act` are low, until the first request arrives.
- R2: Phase codes on `req_ph` select the interval field by fixed word position:
  - 0 selects SCL low, at `tw_data[15:8]`.
  - 1 selects SCL high, at `tw_data[7:0]`.
  - 2 selects START setup, at `tw_start[31:24]`.
  - 3 selects START hold, at `tw_start[23:16]`.
  - 4 selects STOP setup, at `tw_start[15:8]`.
  - 5 selects data setup, at `tw_data[31:24]`.
  - 6 selects data hold, at `tw_hold[7:0]`.
  - 7 selects bus release, at `tw_div[7:0]`.
  - All other word bits are ignored.
- R3: For every phase except SCL high, `done` rises exactly (DIV+1)·(N+1) clock edges after the edge that accepts the request. DIV is `tw_div[23:16]` and N is the selected field.
- R4: For SCL high, the delay is 8 + 2·FLT + (DIV+1)·(N+1) edges, where FLT is `cfg_word[18:16]`.
- R5: `done` is a single-cycle pulse and is never high together with `busy`. `done_ph` shows the code of the phase that just finished.
- R6: A request is accepted only while `busy` is low. A request made while busy has no effect on `cur_ph`, on the timing, or on `bus_act`.
- R7: `bus_act` rises on the acceptance of a START-setup request (code 2). It falls when a bus-release phase (code 7) completes, and at no other time.
- R8: While `bus_act` is high, the timing fields and DIV in use stay as they were at the START. New word values take effect only once the bus is idle again.
- R9: While `scl_stretch` is high after the SCL-high overhead has elapsed, the high count does not begin. Each extra edge of hold-off adds one edge to the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tw_start | input | 32 | START setup, START hold, STOP setup fields |
| tw_data | input | 32 | Data setup, SCL low, SCL high fields |
| tw_div | input | 32 | Prescaler divide and bus-release fields |
| tw_hold | input | 32 | Data hold field |
| cfg_word | input | 32 | Configuration word carrying the filter setting |
| req | input | 1 | Phase request from the sequencer |
| req_ph | input | 3 | Code of the requested phase |
| scl_stretch | input | 1 | Slave hold-off of the SCL-high phase |
| busy | output | 1 | A phase is being timed |
| cur_ph | output | 3 | Code of the phase being timed |
| done | output | 1 | One-cycle end-of-phase strobe |
| done_ph | output | 3 | Code of the phase that last completed |
| bus_act | output | 1 | Transfer in progress; timing fields frozen |

## Verification
The checker watches several properties on every cycle:
- the strobe is a single-cycle pulse that never overlaps `busy`;
- the current phase stays steady while busy, whatever requests arrive;
- `bus_act` changes only on a START acceptance or a release completion;
- the captured field set does not move while the bus is active.

Exact interval lengths need the bench's scenarios:
- the product formula for each phase;
- the filter overhead on SCL high;
- the edge-for-edge cost of a hold-off;
- the correct field being picked out of each word.

The deferred effect of a mid-transfer register write also needs a scenario. It shows only as a difference between two measured durations.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 8;
  localparam int DIV_W    = 8;
  localparam int FLT_W    = 3;
  localparam int FLT_LSB  = 16;
  localparam int OVH_BASE = 8;
  localparam int OVH_MAX  = OVH_BASE + 2 * ((1 << FLT_W) - 1);
  localparam int OVH_W    = $clog2(OVH_MAX + 1);

  typedef enum logic [2:0] {
    PH_LOW    = 3'd0,
    PH_HIGH   = 3'd1,
    PH_STA_SU = 3'd2,
    PH_STA_HD = 3'd3,
    PH_STO_SU = 3'd4,
    PH_DAT_SU = 3'd5,
    PH_DAT_HD = 3'd6,
    PH_REL    = 3'd7
  } phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] sta_su;
    logic [FIELD_W-1:0] sta_hd;
    logic [FIELD_W-1:0] sto_su;
    logic [FIELD_W-1:0] dat_su;
    logic [FIELD_W-1:0] dat_hd;
    logic [FIELD_W-1:0] scl_lo;
    logic [FIELD_W-1:0] scl_hi;
    logic [FIELD_W-1:0] rel;
    logic [DIV_W-1:0]   div;
    logic [FLT_W-1:0]   flt;
  } tcfg_t;
endpackage

// File: rtl/stg_cfg_bank.sv
`timescale 1ns/1ps
// Unpacks the timing words, freezes them while the bus is active,
// and selects the interval field for a requested phase.
module stg_cfg_bank
  import stg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic [WORD_W-1:0]  w_start_i,
  input  logic [WORD_W-1:0]  w_data_i,
  input  logic [WORD_W-1:0]  w_div_i,
  input  logic [WORD_W-1:0]  w_hold_i,
  input  logic [WORD_W-1:0]  w_cfg_i,
  input  phase_e             sel_i,
  output logic [FIELD_W-1:0] fld_o,
  output logic [DIV_W-1:0]   div_o,
  output logic [OVH_W-1:0]   ovh_o,
  output tcfg_t              shd_o
);
  tcfg_t live, eff, shd_q, shd_d;
  logic  unused_bits;

  always_comb begin
    live.sta_su = w_start_i[31:24];
    live.sta_hd = w_start_i[23:16];
    live.sto_su = w_start_i[15:8];
    live.dat_su = w_data_i[31:24];
    live.scl_lo = w_data_i[15:8];
    live.scl_hi = w_data_i[7:0];
    live.div    = w_div_i[23:16];
    live.rel    = w_div_i[7:0];
    live.dat_hd = w_hold_i[7:0];
    live.flt    = w_cfg_i[FLT_LSB +: FLT_W];
  end

  assign unused_bits = ^{w_start_i[7:0], w_data_i[23:16], w_div_i[31:24],
                         w_div_i[15:8], w_hold_i[31:8],
                         w_cfg_i[WORD_W-1:FLT_LSB+FLT_W], w_cfg_i[FLT_LSB-1:0]};

  // shadow copy: clock enable is "bus idle"
  always_comb shd_d = hold_i ? shd_q : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shd_q <= '0;
    else        shd_q <= shd_d;
  end

  assign eff   = hold_i ? shd_q : live;
  assign shd_o = shd_q;
  assign div_o = eff.div;
  assign ovh_o = OVH_W'(OVH_BASE) + OVH_W'({eff.flt, 1'b0});

  always_comb begin
    unique case (sel_i)
      PH_LOW:    fld_o = eff.scl_lo;
      PH_HIGH:   fld_o = eff.scl_hi;
      PH_STA_SU: fld_o = eff.sta_su;
      PH_STA_HD: fld_o = eff.sta_hd;
      PH_STO_SU: fld_o = eff.sto_su;
      PH_DAT_SU: fld_o = eff.dat_su;
      PH_DAT_HD: fld_o = eff.dat_hd;
      default:   fld_o = eff.rel;
    endcase
  end
endmodule

// File: rtl/stg_prescale.sv
`timescale 1ns/1ps
// Shared tick divider: one tick every (div_i+1) running cycles.
module stg_prescale #(
  parameter int W = stg_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (run_i)  cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stg_interval.sv
`timescale 1ns/1ps
// Phase sequencer of the timer: accepts a request, runs the optional
// SCL-high overhead and hold-off, counts ticks, raises the strobe.
module stg_interval
  import stg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  phase_e             req_ph_i,
  input  logic               stretch_i,
  input  logic [FIELD_W-1:0] fld_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [OVH_W-1:0]   ovh_i,
  input  logic               tick_i,
  output logic               run_o,
  output logic               clr_o,
  output logic [DIV_W-1:0]   div_o,
  output logic               busy_o,
  output phase_e             cur_ph_o,
  output logic               done_o,
  output phase_e             done_ph_o,
  output logic               bus_act_o
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_CNT} st_e;

  st_e                st_q, st_d;
  phase_e             ph_q, ph_d, dph_q, dph_d;
  logic [FIELD_W-1:0] tgt_q, tgt_d, pcnt_q, pcnt_d;
  logic [OVH_W-1:0]   ocnt_q, ocnt_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               done_q, done_d, act_q, act_d;
  logic               accept, go, last;

  assign accept = (st_q == S_IDLE) && req_i;
  assign go     = (st_q == S_CNT) ||
                  ((st_q == S_PRE) && (ocnt_q == '0) && !stretch_i);
  assign last   = go && tick_i && (pcnt_q == tgt_q);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    dph_d  = dph_q;
    tgt_d  = tgt_q;
    pcnt_d = pcnt_q;
    ocnt_d = ocnt_q;
    div_d  = div_q;
    done_d = 1'b0;
    act_d  = act_q;
    unique case (st_q)
      S_IDLE: if (req_i) begin
        ph_d   = req_ph_i;
        tgt_d  = fld_i;
        div_d  = div_i;
        pcnt_d = '0;
        if (req_ph_i == PH_HIGH) begin
          ocnt_d = ovh_i;
          st_d   = S_PRE;
        end else begin
          ocnt_d = '0;
          st_d   = S_CNT;
        end
      end
      S_PRE: begin
        if (ocnt_q != '0)    ocnt_d = ocnt_q - 1'b1;
        else if (!stretch_i) st_d   = S_CNT;
      end
      default: ;
    endcase
    if (go && tick_i) begin
      if (last) begin
        st_d   = S_IDLE;
        done_d = 1'b1;
        dph_d  = ph_q;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
    if (accept && (req_ph_i == PH_STA_SU)) act_d = 1'b1;
    else if (last && (ph_q == PH_REL))     act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= PH_LOW;
      dph_q  <= PH_LOW;
      tgt_q  <= '0;
      pcnt_q <= '0;
      ocnt_q <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      dph_q  <= dph_d;
      tgt_q  <= tgt_d;
      pcnt_q <= pcnt_d;
      ocnt_q <= ocnt_d;
      div_q  <= div_d;
      done_q <= done_d;
      act_q  <= act_d;
    end
  end

  assign run_o     = go;
  assign clr_o     = accept;
  assign div_o     = div_q;
  assign busy_o    = (st_q != S_IDLE);
  assign cur_ph_o  = ph_q;
  assign done_o    = done_q;
  assign done_ph_o = dph_q;
  assign bus_act_o = act_q;
endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import stg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tw_start,
  input  logic [WORD_W-1:0] tw_data,
  input  logic [WORD_W-1:0] tw_div,
  input  logic [WORD_W-1:0] tw_hold,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              req,
  input  logic [2:0]        req_ph,
  input  logic              scl_stretch,
  output logic              busy,
  output logic [2:0]        cur_ph,
  output logic              done,
  output logic [2:0]        done_ph,
  output logic              bus_act
);
  logic [FIELD_W-1:0] fld;
  logic [DIV_W-1:0]   div_sel, div_run;
  logic [OVH_W-1:0]   ovh;
  tcfg_t              shd_cfg;
  logic               tick, run, clr;
  phase_e             cur_e, done_e;

  stg_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .hold_i(bus_act),
    .w_start_i(tw_start), .w_data_i(tw_data), .w_div_i(tw_div),
    .w_hold_i(tw_hold), .w_cfg_i(cfg_word), .sel_i(phase_e'(req_ph)),
    .fld_o(fld), .div_o(div_sel), .ovh_o(ovh), .shd_o(shd_cfg)
  );

  stg_prescale #(.W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .run_i(run),
    .div_i(div_run), .tick_o(tick)
  );

  stg_interval u_ivl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_ph_i(phase_e'(req_ph)),
    .stretch_i(scl_stretch), .fld_i(fld), .div_i(div_sel), .ovh_i(ovh),
    .tick_i(tick), .run_o(run), .clr_o(clr), .div_o(div_run),
    .busy_o(busy), .cur_ph_o(cur_e), .done_o(done), .done_ph_o(done_e),
    .bus_act_o(bus_act)
  );

  assign cur_ph  = cur_e;
  assign done_ph = done_e;
endmodule

// File: rtl/scl_timing_gen_chk.sv
`timescale 1ns/1ps
module scl_timing_gen_chk
  import stg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic [2:0] req_ph,
  input logic       busy,
  input logic [2:0] cur_ph,
  input logic       done,
  input logic [2:0] done_ph,
  input logic       bus_act,
  input tcfg_t      shd
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || (busy && $stable(cur_ph))));
  // R7
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_act) |-> $past(req && !busy && (req_ph == 3'd2)));
  // R7
  act_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_act) |-> (done && (done_ph == 3'd7)));
  // R8
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && $past(bus_act)) |-> $stable(shd));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_ph(req_ph), .busy(busy),
  .cur_ph(cur_ph), .done(done), .done_ph(done_ph), .bus_act(bus_act),
  .shd(shd_cfg)
);

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tw_start, tw_data, tw_div, tw_hold, cfg_word;
  logic        req, scl_stretch;
  logic [2:0]  req_ph;
  logic        busy, done, bus_act;
  logic [2:0]  cur_ph, done_ph;

  int  errs = 0;
  int  chks = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  scl_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tw_start(tw_start), .tw_data(tw_data),
    .tw_div(tw_div), .tw_hold(tw_hold), .cfg_word(cfg_word), .req(req),
    .req_ph(req_ph), .scl_stretch(scl_stretch), .busy(busy),
    .cur_ph(cur_ph), .done(done), .done_ph(done_ph), .bus_act(bus_act)
  );

  localparam logic [7:0] F_STA_SU = 8'd5, F_STA_HD = 8'd6, F_STO_SU = 8'd7,
                         F_DAT_SU = 8'd3, F_DAT_HD = 8'd2, F_LO = 8'd9,
                         F_HI = 8'd8, F_REL = 8'd10;

  // {phase, div, filter}
  localparam logic [13:0] VEC [11] = '{
    {3'd0, 8'd0, 3'd0}, {3'd1, 8'd0, 3'd0}, {3'd1, 8'd2, 3'd5},
    {3'd4, 8'd1, 3'd0}, {3'd5, 8'd3, 3'd0}, {3'd6, 8'd0, 3'd7},
    {3'd3, 8'd4, 3'd0}, {3'd7, 8'd1, 3'd0}, {3'd2, 8'd2, 3'd0},
    {3'd0, 8'd2, 3'd0}, {3'd7, 8'd2, 3'd0}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic set_cfg(input int dv, input int fl, input int lo);
    tw_start = {F_STA_SU, F_STA_HD, F_STO_SU, 8'hA5};
    tw_data  = {F_DAT_SU, 8'h5A, 8'(lo), F_HI};
    tw_div   = {8'hC3, 8'(dv), 8'h3C, F_REL};
    tw_hold  = {24'hDEAD5A, F_DAT_HD};
    cfg_word = {13'h1ABC, 3'(fl), 16'hBEEF};
  endtask

  function automatic int fld_of(input int ph);
    case (ph)
      0: return F_LO;     1: return F_HI;
      2: return F_STA_SU; 3: return F_STA_HD;
      4: return F_STO_SU; 5: return F_DAT_SU;
      6: return F_DAT_HD; default: return F_REL;
    endcase
  endfunction

  function automatic int exp_len(input int ph, input int dv, input int fl, input int f);
    return (dv + 1) * (f + 1) + ((ph == 1) ? (8 + 2 * fl) : 0);
  endfunction

  // s_rel: edge count at which the hold-off drops (-1: none)
  // inj: edge count at which a START-setup request is pushed while busy (-1: none)
  task automatic do_phase(input logic [2:0] ph, input int s_rel, input int inj,
                          output int k, output logic [2:0] dph);
    @(negedge clk); req = 1'b1; req_ph = ph;
    @(negedge clk); req = 1'b0; k = 0;
    forever begin
      if (k == s_rel) scl_stretch = 1'b0;
      if (k == inj) begin req = 1'b1; req_ph = 3'd2; end
      else if (inj >= 0 && k == inj + 1) begin
        req = 1'b0;
        check(cur_ph == ph, "R6 phase kept", int'(cur_ph), int'(ph));
      end
      @(posedge clk); k++;
      @(negedge clk);
      if (done || k > 70000) break;
    end
    dph = done_ph;
    @(negedge clk);
    check(done == 1'b0, "R5 strobe width", int'(done), 0);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      errs++; chks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    int k;
    logic [2:0] dph;
    bit act_exp;
    rst_n = 1'b0; req = 1'b0; req_ph = 3'd0; scl_stretch = 1'b0;
    set_cfg(0, 0, F_LO);
    repeat (3) @(negedge clk);
    check(!done && !busy && !bus_act, "R1 in reset", int'({done, busy, bus_act}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !busy && !bus_act, "R1 after reset", int'({done, busy, bus_act}), 0);

    // table walk: R2 R3 R4 R5 R7
    act_exp = 1'b0;
    foreach (VEC[i]) begin
      int ph, dv, fl, e;
      ph = int'(VEC[i][13:11]); dv = int'(VEC[i][10:3]); fl = int'(VEC[i][2:0]);
      set_cfg(dv, fl, F_LO);
      e = exp_len(ph, dv, fl, fld_of(ph));
      do_phase(3'(ph), -1, -1, k, dph);
      check(k == e, (ph == 1) ? "R4 high length" : "R3 R2 phase length", k, e);
      check(int'(dph) == ph, "R5 done phase", int'(dph), ph);
      if (ph == 2) act_exp = 1'b1;
      else if (ph == 7) act_exp = 1'b0;
      check(bus_act == act_exp, "R7 bus active", int'(bus_act), int'(act_exp));
    end

    // R8: write during transfer is deferred
    set_cfg(0, 0, F_LO);
    do_phase(3'd2, -1, -1, k, dph);
    check(k == 6, "R8 start setup", k, 6);
    set_cfg(3, 0, 20);
    do_phase(3'd0, -1, -1, k, dph);
    check(k == 10, "R8 old low kept", k, 10);
    do_phase(3'd7, -1, -1, k, dph);
    check(k == 11, "R8 old release kept", k, 11);
    check(bus_act == 1'b0, "R7 release ends transfer", int'(bus_act), 0);
    do_phase(3'd0, -1, -1, k, dph);
    check(k == 84, "R8 new low after idle", k, 84);

    // R9: hold-off of the high phase
    set_cfg(1, 0, F_LO);
    scl_stretch = 1'b1;
    do_phase(3'd1, 13, -1, k, dph);
    check(k == 31, "R9 stretched high", k, 31);

    // R6: request while busy ignored
    set_cfg(0, 0, F_LO);
    do_phase(3'd0, -1, 3, k, dph);
    check(k == 10, "R6 length unchanged", k, 10);
    check(dph == 3'd0, "R6 done phase", int'(dph), 0);
    check(bus_act == 1'b0, "R6 no transfer start", int'(bus_act), 0);
    check(!busy, "R6 idle after", int'(busy), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule